// File: doc/BRIEF.md
# Pipelined Integer Multiply-Accumulate Unit

This unit multiplies two 64-bit source operands and adds the product to, or subtracts it from, a third operand that holds the destination's previous value. Only the low 64 bits of any product or sum are kept.

Beyond the plain full-width forms, two narrower families exist:
- The word family truncates the sum or difference to 32 bits and sign-extends it back to 64.
- The halfword family uses only the low 16 bits of each source, each sign-extended, and sign-extends the 32-bit outcome.

A mode input says whether the surrounding core runs with 64-bit or 32-bit registers. Word operations are not permitted in 32-bit mode and are reported as illegal.

Operands enter through a valid/ready handshake. The result leaves two register stages later with a valid strobe. A downstream ready signal can freeze the whole pipeline, which drops the input ready.

Top module: `mac_unit`

## Requirements
- R1: After reset `out_valid` and `out_illegal` are 0 and `in_ready` is 1.
- R2: Op code 0 (multiply-add) returns the low 64 bits of acc + src1 × src2 in 64-bit mode.
- R3: Op code 1 (multiply-subtract) returns the low 64 bits of acc − src1 × src2, wrapping modulo 2^64, in 64-bit mode.
- R4: Op codes 2 (add) and 3 (subtract) form the same sum or difference as R2/R3, then replace bits 63:32 with copies of bit 31.
- R5: Op codes 4 (add) and 5 (subtract) sign-extend bits 15:0 of each source, multiply, add to or subtract from acc, and sign-extend bit 31 of the result; source bits 63:16 have no effect on the result.
- R6: When `wide_mode` is 0 and the op code is 2 or 3, or whenever the op code is 6 or 7, `out_illegal` is 1 and `out_result` is 0.
- R7: Halfword op codes 4 and 5 give the same result in both modes and are never flagged illegal.
- R8: With `wide_mode` 0, op codes 0 and 1 return the low 32 bits of the sum or difference sign-extended from bit 31.
- R9: A request accepted on a clock edge with `out_ready` held at 1 is presented on `out_valid` after the next edge, and not before.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output holds its value and `in_ready` is 0; a held result is delivered exactly once.
- R11: With `out_ready` held at 1, one request can be accepted every cycle, and results emerge in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted on this edge when both are high |
| in_op | input | 3 | Operation code (see R2–R6) |
| wide_mode | input | 1 | 1 = 64-bit register mode, 0 = 32-bit mode |
| in_src1 | input | 64 | First multiplicand |
| in_src2 | input | 64 | Second multiplicand |
| in_acc | input | 64 | Prior destination value used as accumulator |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream can take the result |
| out_result | output | 64 | Result value |
| out_illegal | output | 1 | Request was not permitted in the given mode |

## Verification
The hardest state to reach is a backpressure stall with a result parked at the output while a second request waits at the input. When the stall is released, the parked result must leave exactly once and the waiting request must enter.

The stimulus sends one request and lowers `out_ready` before the result arrives. It then keeps a different request valid for several frozen cycles and checks that the output and `in_ready` do not move. Finally it raises `out_ready` and checks that a bubble, then the second result, appear.

The halfword tests fill the upper bits of both sources with noise to prove those bits are ignored.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        OP_ADD_FULL = 3'd0,
        OP_SUB_FULL = 3'd1,
        OP_ADD_WORD = 3'd2,
        OP_SUB_WORD = 3'd3,
        OP_ADD_HALF = 3'd4,
        OP_SUB_HALF = 3'd5
    } mac_op_e;

    function automatic logic op_is_half(input logic [2:0] op);
        return (op == OP_ADD_HALF) || (op == OP_SUB_HALF);
    endfunction

    function automatic logic op_is_word(input logic [2:0] op);
        return (op == OP_ADD_WORD) || (op == OP_SUB_WORD);
    endfunction

    // Odd codes subtract the product from the accumulator.
    function automatic logic op_is_sub(input logic [2:0] op);
        return op[0];
    endfunction

    // Word ops need 64-bit mode; codes 6 and 7 are reserved.
    function automatic logic op_illegal(input logic [2:0] op, input logic wide);
        return (op > 3'd5) || (op_is_word(op) && !wide);
    endfunction

endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep
    import mac_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int HALF_W = 16
) (
    input  logic [2:0]            op,
    input  logic [1:0][XLEN-1:0]  src_i,
    output logic [1:0][XLEN-1:0]  src_o
);
    localparam int PAD_W = XLEN - HALF_W;

    for (genvar k = 0; k < 2; k++) begin : g_src
        always_comb begin
            if (op_is_half(op)) begin
                src_o[k] = {{PAD_W{src_i[k][HALF_W-1]}}, src_i[k][HALF_W-1:0]};
            end else begin
                src_o[k] = src_i[k];
            end
        end
    end

endmodule

// File: rtl/mac_result_fmt.sv
module mac_result_fmt
    import mac_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32
) (
    input  logic [2:0]      op,
    input  logic            wide,
    input  logic [XLEN-1:0] prod,
    input  logic [XLEN-1:0] acc,
    output logic [XLEN-1:0] res,
    output logic            illegal
);
    localparam int PAD_W = XLEN - WORD_W;

    logic [XLEN-1:0] raw;
    logic            narrow;

    always_comb begin
        raw     = op_is_sub(op) ? (acc - prod) : (acc + prod);
        narrow  = op_is_word(op) || op_is_half(op) || !wide;
        illegal = op_illegal(op, wide);
        if (illegal) begin
            res = '0;
        end else if (narrow) begin
            res = {{PAD_W{raw[WORD_W-1]}}, raw[WORD_W-1:0]};
        end else begin
            res = raw;
        end
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32,
    parameter int HALF_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [2:0]      in_op,
    input  logic            wide_mode,
    input  logic [XLEN-1:0] in_src1,
    input  logic [XLEN-1:0] in_src2,
    input  logic [XLEN-1:0] in_acc,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [XLEN-1:0] out_result,
    output logic            out_illegal
);

    typedef struct packed {
        logic            s1_vld;
        logic [2:0]      s1_op;
        logic            s1_wide;
        logic [XLEN-1:0] s1_prod;
        logic [XLEN-1:0] s1_acc;
        logic            s2_vld;
        logic [XLEN-1:0] s2_res;
        logic            s2_ill;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [1:0][XLEN-1:0] raw_src;
    logic [1:0][XLEN-1:0] ext_src;
    logic [XLEN-1:0]      prod;
    logic [XLEN-1:0]      fmt_res;
    logic                 fmt_ill;
    logic                 advance;

    assign raw_src[0] = in_src1;
    assign raw_src[1] = in_src2;

    mac_operand_prep #(.XLEN(XLEN), .HALF_W(HALF_W)) prep_i (
        .op    (in_op),
        .src_i (raw_src),
        .src_o (ext_src)
    );

    assign prod = ext_src[0] * ext_src[1];

    mac_result_fmt #(.XLEN(XLEN), .WORD_W(WORD_W)) fmt_i (
        .op      (pipe_q.s1_op),
        .wide    (pipe_q.s1_wide),
        .prod    (pipe_q.s1_prod),
        .acc     (pipe_q.s1_acc),
        .res     (fmt_res),
        .illegal (fmt_ill)
    );

    // Whole pipeline freezes while a result waits at the output.
    assign advance = !pipe_q.s2_vld || out_ready;

    always_comb begin
        pipe_d = pipe_q;
        if (advance) begin
            pipe_d.s1_vld  = in_valid;
            pipe_d.s1_op   = in_op;
            pipe_d.s1_wide = wide_mode;
            pipe_d.s1_prod = prod;
            pipe_d.s1_acc  = in_acc;
            pipe_d.s2_vld  = pipe_q.s1_vld;
            pipe_d.s2_res  = fmt_res;
            pipe_d.s2_ill  = fmt_ill && pipe_q.s1_vld;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign in_ready    = advance;
    assign out_valid   = pipe_q.s2_vld;
    assign out_result  = pipe_q.s2_res;
    assign out_illegal = pipe_q.s2_ill;

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic [XLEN-1:0] out_result,
    input logic            out_illegal
);

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

    p_ready_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 in_ready |=> out_valid);

    p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_result == '0));

    p_illegal_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_illegal);

endmodule

bind mac_unit mac_unit_chk #(.XLEN(XLEN)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = 3'd0;
    logic        wide_mode = 1'b1;
    logic [63:0] in_src1 = '0;
    logic [63:0] in_src2 = '0;
    logic [63:0] in_acc = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_result;
    logic        out_illegal;

    int n_checks = 0;
    int n_fails  = 0;

    always #5ns clk = ~clk;

    mac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .wide_mode(wide_mode), .in_src1(in_src1), .in_src2(in_src2),
        .in_acc(in_acc), .out_valid(out_valid), .out_ready(out_ready),
        .out_result(out_result), .out_illegal(out_illegal)
    );

    function automatic logic [63:0] sx32(input logic [63:0] v);
        return {{32{v[31]}}, v[31:0]};
    endfunction

    function automatic logic model_ill(input logic [2:0] op, input logic wide);
        return (op >= 3'd6) || ((op == 3'd2 || op == 3'd3) && !wide);
    endfunction

    function automatic logic [63:0] model_res(input logic [2:0] op, input logic wide,
                                              input logic [63:0] a, input logic [63:0] b,
                                              input logic [63:0] c);
        logic [63:0] p, r;
        if (model_ill(op, wide)) return 64'd0;
        if (op == 3'd4 || op == 3'd5) begin
            p = {{48{a[15]}}, a[15:0]} * {{48{b[15]}}, b[15:0]};
        end else begin
            p = a * b;
        end
        r = op[0] ? (c - p) : (c + p);
        if (op >= 3'd2 || !wide) r = sx32(r);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic wide, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] c);
        in_valid = 1'b1; in_op = op; wide_mode = wide;
        in_src1 = a; in_src2 = b; in_acc = c;
    endtask

    // One request through an empty pipe with out_ready high; checks latency too.
    task automatic one_op(input string req, input logic [2:0] op, input logic wide,
                          input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
        logic [63:0] exp;
        exp = model_res(op, wide, a, b, c);
        @(negedge clk);
        drive(op, wide, a, b, c);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R9 early", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check(out_valid == 1'b1, "R9 valid", {63'd0, out_valid}, 64'd1);
        check(out_result == exp, req, out_result, exp);
        check(out_illegal == model_ill(op, wide), {req, " illegal"},
              {63'd0, out_illegal}, {63'd0, model_ill(op, wide)});
    endtask

    task automatic t_reset;
        check(out_valid == 1'b0, "R1 out_valid", {63'd0, out_valid}, 64'd0);
        check(out_illegal == 1'b0, "R1 out_illegal", {63'd0, out_illegal}, 64'd0);
        check(in_ready == 1'b1, "R1 in_ready", {63'd0, in_ready}, 64'd1);
    endtask

    task automatic t_full;
        one_op("R2 add", 3'd0, 1'b1, 64'd123456789, 64'd987654321, 64'd42);
        one_op("R2 add big", 3'd0, 1'b1, 64'hFFFF_FFFF_0000_0003, 64'h1_0000_0001, 64'h7);
        one_op("R3 sub wrap", 3'd1, 1'b1, 64'd5, 64'd7, 64'd10);
        one_op("R3 sub neg", 3'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 64'd100);
    endtask

    task automatic t_word;
        one_op("R4 add sext", 3'd2, 1'b1, 64'h0000_0001_4000_0000, 64'd2, 64'h0000_0000_0000_0001);
        one_op("R4 sub sext", 3'd3, 1'b1, 64'd1, 64'd2, 64'h1234_5678_0000_0001);
        one_op("R4 add pos", 3'd2, 1'b1, 64'd3, 64'd4, 64'hABCD_0000_0000_0010);
    endtask

    task automatic t_half;
        one_op("R5 add noise", 3'd4, 1'b1, 64'hDEAD_BEEF_1234_FFFE, 64'h5555_AAAA_0F0F_0003, 64'd10);
        one_op("R5 sub noise", 3'd5, 1'b1, 64'hFFFF_0000_0000_8000, 64'h0123_4567_89AB_8000, 64'd0);
        one_op("R7 half narrow add", 3'd4, 1'b0, 64'hDEAD_BEEF_1234_FFFE, 64'h5555_AAAA_0F0F_0003, 64'd10);
        one_op("R7 half narrow sub", 3'd5, 1'b0, 64'h7777_0000_0000_7FFF, 64'h0000_0000_0000_7FFF, 64'h1);
    endtask

    task automatic t_mode;
        one_op("R6 word narrow add", 3'd2, 1'b0, 64'd3, 64'd4, 64'd5);
        one_op("R6 word narrow sub", 3'd3, 1'b0, 64'd3, 64'd4, 64'd5);
        one_op("R6 reserved 6", 3'd6, 1'b1, 64'd3, 64'd4, 64'd5);
        one_op("R6 reserved 7", 3'd7, 1'b1, 64'd3, 64'd4, 64'd5);
        one_op("R8 full narrow add", 3'd0, 1'b0, 64'h0000_0001_7FFF_FFFF, 64'd1, 64'd1);
        one_op("R8 full narrow sub", 3'd1, 1'b0, 64'd2, 64'd3, 64'h0000_0009_0000_0000);
    endtask

    task automatic t_stall;
        logic [63:0] ea, eb;
        ea = model_res(3'd0, 1'b1, 64'd11, 64'd13, 64'd17);
        eb = model_res(3'd1, 1'b1, 64'd19, 64'd23, 64'd29);
        @(negedge clk);
        out_ready = 1'b0;
        drive(3'd0, 1'b1, 64'd11, 64'd13, 64'd17);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid && out_result == ea, "R10 parked", out_result, ea);
        drive(3'd1, 1'b1, 64'd19, 64'd23, 64'd29);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R10 in_ready low", {63'd0, in_ready}, 64'd0);
            check(out_valid && out_result == ea, "R10 hold", out_result, ea);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R10 once", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check(out_valid && out_result == eb, "R10 waiting req", out_result, eb);
        @(negedge clk);
        check(out_valid == 1'b0, "R10 drained", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_stream;
        logic [63:0] sa [6];
        logic [63:0] sb [6];
        logic [63:0] sc [6];
        for (int i = 0; i < 6; i++) begin
            sa[i] = 64'h0101_0101_0101_0101 * (i + 3);
            sb[i] = 64'hF00D + 64'(i * 977);
            sc[i] = 64'h8000_0000_0000_0000 - 64'(i * 31);
        end
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                logic [63:0] e;
                e = model_res(3'(c - 2), 1'b1, sa[c-2], sb[c-2], sc[c-2]);
                check(out_valid && out_result == e, "R11 stream order", out_result, e);
            end
            if (c < 6) drive(3'(c), 1'b1, sa[c], sb[c], sc[c]);
            else in_valid = 1'b0;
        end
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_word();
        t_half();
        t_mode();
        t_stall();
        t_stream();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule